// File: doc/BRIEF.md
# Fractional SPI Serial Clock Generator

This block derives a serial clock and two single-cycle strobes, one to launch data and one to sample it, from a fast reference clock. It uses an 11-bit phase accumulator in place of an integer divider. On every reference cycle the active profile's increment is added to the accumulator. Each carry out of the 2048 modulus toggles the serial clock, so the clock rate is the reference rate times the increment divided by 4096. The wrap rate itself is reference times increment over 2048. A profile can also clear the accumulator on every carry instead of keeping the remainder. That trades the exact fractional average for an even, integer toggle period.

A profile is captured with a single load strobe and holds four fields: the increment, the clear-on-carry choice, and the edge directions for launch and for sample. Loading a profile restarts the accumulator and returns the clock to idle. Two global inputs apply on top of the profile. One sets the idle level of the clock. The other, when set, parks the clock at idle whenever no slave select is active. The strobes feed an external shifter. Every output is registered and changes on the same reference edge.

Top module: `spi_acc_clkgen`

## Requirements
- R1: With clear-on-carry off and effective increment E, the serial clock toggles exactly floor(N*E/2048) times over the N reference edges that follow a load edge.
- R2: An increment of 1024 or more behaves exactly like 1024, so the clock toggles at most once every two reference cycles.
- R3: With clear-on-carry on (`prof_wrap_clear`=1) and E>0, the clock toggles once every ceil(2048/E) reference edges, so it toggles floor(N/ceil(2048/E)) times over N edges.
- R4: At rest `sck` equals `cpol_idle_high`. Starting from idle, the first toggle moves it away from that level, and later toggles alternate.
- R5: `launch_stb` is high for exactly the reference cycles in which `sck` has just taken a new value equal to `prof_launch_rise` (1 = launch on rising edges, 0 = on falling edges), and is low at all other times.
- R6: `sample_stb` follows the same rule with `prof_latch_rise` (1 = sample on rising edges, 0 = on falling edges).
- R7: While `gate_when_idle`=1 and `cs_active`=0, `sck` sits at the idle level, both strobes stay low, and the accumulator restarts from 0. When select returns, R1 and R3 counting begins anew. With `gate_when_idle`=0 the clock runs whatever the value of `cs_active`.
- R8: An increment of 0 keeps `sck` at idle and both strobes low.
- R9: In the cycle after a `prof_load` edge, `sck` equals the idle level and both strobes are low, whatever state the clock was in before.
- R10: After synchronous reset, `sck` equals `cpol_idle_high` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_load | input | 1 | Capture the profile fields and restart the clock |
| prof_inc | input | ACC_W | Phase increment per reference cycle (modulus 2^ACC_W) |
| prof_wrap_clear | input | 1 | Clear the accumulator on each carry |
| prof_launch_rise | input | 1 | Launch on rising (1) or falling (0) edges |
| prof_latch_rise | input | 1 | Sample on rising (1) or falling (0) edges |
| cpol_idle_high | input | 1 | Idle level of the serial clock |
| gate_when_idle | input | 1 | Park the clock while no select is active |
| cs_active | input | 1 | Some slave select is active |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle launch strobe |
| sample_stb | output | 1 | One-cycle sample strobe |

## Verification
The bench sweeps increments from zero through the clamp boundary (1023, 1024, 1500, 2047). It tries each increment with both carry modes, both idle polarities and both edge pairings, and compares toggle and strobe counts against closed-form values. An off-by-one in when the carry is consumed would shift each count by about one wrap. A missing clamp would give twice the rate or a corrupted rate above 1024. Keeping the remainder in clear-on-carry mode would show the fractional count instead of the integer-period count. Every cycle, the bench also checks that each strobe lines up with an `sck` transition of the selected direction, so an inverted edge select shows up at once. Gating and reload tests look for a clock that fails to park at idle or that resumes from stale accumulator phase.

// File: rtl/spi_acc_clkgen_pkg.sv
package spi_acc_clkgen_pkg;

  typedef struct packed {
    logic wrap_clear;
    logic launch_rise;
    logic latch_rise;
  } prof_ctl_t;

endpackage

// File: rtl/sacg_profile.sv
module sacg_profile
  import spi_acc_clkgen_pkg::*;
#(
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ACC_W-1:0] inc_in,
  input  prof_ctl_t        ctl_in,
  output logic [ACC_W-1:0] inc_q,
  output prof_ctl_t        ctl_q
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] inc_clamped;

  always_comb begin
    inc_clamped = (inc_in >= HALF) ? HALF : inc_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= '0;
      ctl_q <= '0;
    end else if (load) begin
      inc_q <= inc_clamped;
      ctl_q <= ctl_in;
    end
  end
endmodule

// File: rtl/sacg_accum.sv
module sacg_accum #(
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [ACC_W-1:0] inc,
  input  logic             wrap_clear,
  output logic             wrap
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, inc};
    wrap = sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (wrap && wrap_clear) begin
      acc_q <= '0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/sacg_edges.sv
module sacg_edges (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic wrap,
  input  logic cpol,
  input  logic launch_rise,
  input  logic latch_rise,
  output logic sck,
  output logic launch_stb,
  output logic sample_stb
);
  logic ph_q;
  logic ph_next;
  logic toggle;
  logic sck_next;

  always_comb begin
    toggle   = wrap && !clr;
    ph_next  = clr ? 1'b0 : (ph_q ^ wrap);
    sck_next = ph_next ^ cpol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= 1'b0;
      sck        <= cpol;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      ph_q       <= ph_next;
      sck        <= sck_next;
      launch_stb <= toggle && (sck_next == launch_rise);
      sample_stb <= toggle && (sck_next == latch_rise);
    end
  end
endmodule

// File: rtl/spi_acc_clkgen.sv
module spi_acc_clkgen
  import spi_acc_clkgen_pkg::*;
#(
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prof_load,
  input  logic [ACC_W-1:0] prof_inc,
  input  logic             prof_wrap_clear,
  input  logic             prof_launch_rise,
  input  logic             prof_latch_rise,
  input  logic             cpol_idle_high,
  input  logic             gate_when_idle,
  input  logic             cs_active,
  output logic             sck,
  output logic             launch_stb,
  output logic             sample_stb
);
  prof_ctl_t        ctl_in;
  prof_ctl_t        ctl_q;
  logic [ACC_W-1:0] inc_q;
  logic             hold;
  logic             clr;
  logic             wrap;

  always_comb begin
    ctl_in.wrap_clear  = prof_wrap_clear;
    ctl_in.launch_rise = prof_launch_rise;
    ctl_in.latch_rise  = prof_latch_rise;
    hold = gate_when_idle && !cs_active;
    clr  = prof_load || hold;
  end

  sacg_profile #(.ACC_W(ACC_W)) u_profile (
    .clk    (clk),
    .rst    (rst),
    .load   (prof_load),
    .inc_in (prof_inc),
    .ctl_in (ctl_in),
    .inc_q  (inc_q),
    .ctl_q  (ctl_q)
  );

  sacg_accum #(.ACC_W(ACC_W)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .inc        (inc_q),
    .wrap_clear (ctl_q.wrap_clear),
    .wrap       (wrap)
  );

  sacg_edges u_edges (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .wrap        (wrap),
    .cpol        (cpol_idle_high),
    .launch_rise (ctl_q.launch_rise),
    .latch_rise  (ctl_q.latch_rise),
    .sck         (sck),
    .launch_stb  (launch_stb),
    .sample_stb  (sample_stb)
  );
endmodule

// File: rtl/spi_acc_clkgen_chk.sv
module spi_acc_clkgen_chk #(
  parameter int ACC_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             hold,
  input logic             cpol,
  input logic             sck,
  input logic             launch_stb,
  input logic             sample_stb,
  input logic [ACC_W-1:0] inc_q,
  input logic             launch_rise,
  input logic             latch_rise
);
  // R5: a launch pulse sits on an sck transition of the chosen direction
  a_r5_launch_on_edge: assert property (@(posedge clk) disable iff (rst)
    (launch_stb && $stable(cpol)) |-> (sck != $past(sck)) && (sck == launch_rise));

  // R6: a sample pulse sits on an sck transition of the chosen direction
  a_r6_sample_on_edge: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && $stable(cpol)) |-> (sck != $past(sck)) && (sck == latch_rise));

  // R7: gated clock parks at idle with no strobes
  a_r7_gate_parks: assert property (@(posedge clk) disable iff (rst)
    hold |=> (sck == $past(cpol)) && !launch_stb && !sample_stb);

  // R9: loading a profile returns the clock to idle
  a_r9_load_idles: assert property (@(posedge clk) disable iff (rst)
    load |=> (sck == $past(cpol)) && !launch_stb && !sample_stb);

  // R8: zero increment never produces a strobe
  a_r8_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (inc_q == '0 && !load) |=> !launch_stb && !sample_stb);

  // R5/R6: opposite edge choices never strobe together
  a_r5_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    (launch_rise != latch_rise) |-> !(launch_stb && sample_stb));
endmodule

bind spi_acc_clkgen spi_acc_clkgen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load        (prof_load),
  .hold        (hold),
  .cpol        (cpol_idle_high),
  .sck         (sck),
  .launch_stb  (launch_stb),
  .sample_stb  (sample_stb),
  .inc_q       (inc_q),
  .launch_rise (ctl_q.launch_rise),
  .latch_rise  (ctl_q.latch_rise)
);

// File: tb/spi_acc_clkgen_bench.sv
module spi_acc_clkgen_bench;
  localparam int ACC_W = 11;
  localparam int RUN_N = 700;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             prof_load = 1'b0;
  logic [ACC_W-1:0] prof_inc = '0;
  logic             prof_wrap_clear = 1'b0;
  logic             prof_launch_rise = 1'b0;
  logic             prof_latch_rise = 1'b0;
  logic             cpol_idle_high = 1'b0;
  logic             gate_when_idle = 1'b0;
  logic             cs_active = 1'b0;
  logic             sck;
  logic             launch_stb;
  logic             sample_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  spi_acc_clkgen #(.ACC_W(ACC_W)) u_spi_acc_clkgen (
    .clk              (clk),
    .rst              (rst),
    .prof_load        (prof_load),
    .prof_inc         (prof_inc),
    .prof_wrap_clear  (prof_wrap_clear),
    .prof_launch_rise (prof_launch_rise),
    .prof_latch_rise  (prof_latch_rise),
    .cpol_idle_high   (cpol_idle_high),
    .gate_when_idle   (gate_when_idle),
    .cs_active        (cs_active),
    .sck              (sck),
    .launch_stb       (launch_stb),
    .sample_stb       (sample_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_toggles(input int inc, input bit wclr, input int n);
    int e = (inc >= 1024) ? 1024 : inc;
    if (e == 0) return 0;
    if (!wclr) return (n * e) / 2048;
    return n / ((2048 + e - 1) / e);
  endfunction

  // R4: toggles alternate starting away from idle; count new values equal v
  function automatic int exp_edges(input int t, input bit cpol, input bit v);
    return (v != cpol) ? (t + 1) / 2 : t / 2;
  endfunction

  task automatic count_run(input int n, input int inc, input bit wclr,
                           input bit cpol, input bit lr, input bit sr,
                           input string tag);
    int tog = 0;
    int nl = 0;
    int ns = 0;
    int et;
    logic prev = sck;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      begin
        bit tr = (sck != prev);
        bit el = tr && (sck == lr);
        bit es = tr && (sck == sr);
        if (tr) tog++;
        if (launch_stb) nl++;
        if (sample_stb) ns++;
        check(launch_stb == el, "R5", int'(launch_stb), int'(el));
        check(sample_stb == es, "R6", int'(sample_stb), int'(es));
        if (tog == 1 && tr) check(sck == !cpol, "R4", int'(sck), int'(!cpol));
        prev = sck;
      end
    end
    et = exp_toggles(inc, wclr, n);
    if (inc == 0) check(tog == 0, "R8", tog, 0);
    else if (inc >= 1024) check(tog == et, "R2", tog, et);
    else if (wclr) check(tog == et, "R3", tog, et);
    else check(tog == et, "R1", tog, et);
    check(nl == exp_edges(et, cpol, lr), {"R5 count ", tag}, nl, exp_edges(et, cpol, lr));
    check(ns == exp_edges(et, cpol, sr), {"R6 count ", tag}, ns, exp_edges(et, cpol, sr));
  endtask

  task automatic load_profile(input int inc, input bit wclr, input bit cpol,
                              input bit lr, input bit sr);
    @(negedge clk);
    prof_inc         = ACC_W'(inc);
    prof_wrap_clear  = wclr;
    prof_launch_rise = lr;
    prof_latch_rise  = sr;
    cpol_idle_high   = cpol;
    prof_load        = 1'b1;
    @(negedge clk);
    prof_load = 1'b0;
    // R9: idle in the cycle after the load edge
    check(sck == cpol && !launch_stb && !sample_stb, "R9", int'(sck), int'(cpol));
  endtask

  initial begin
    int incs[11] = '{0, 1, 3, 7, 100, 512, 700, 1023, 1024, 1500, 2047};
    repeat (3) @(negedge clk);
    // R10: reset state
    check(sck == 1'b0 && !launch_stb && !sample_stb, "R10", int'(sck), 0);
    rst = 1'b0;

    foreach (incs[k]) begin
      for (int m = 0; m < 8; m++) begin
        bit wclr = m[0];
        bit cpol = m[1];
        bit lr   = m[2];
        // R7: with gating off, the clock runs even with no select
        gate_when_idle = wclr;
        cs_active      = wclr;
        load_profile(incs[k], wclr, cpol, lr, !lr);
        count_run(RUN_N, incs[k], wclr, cpol, lr, !lr, "sweep");
      end
    end

    // Same-edge pairing: both strobes on every rising edge
    load_profile(700, 1'b0, 1'b1, 1'b1, 1'b1);
    count_run(RUN_N, 700, 1'b0, 1'b1, 1'b1, 1'b1, "same");

    // R7: gate parks the clock, then restart from zero phase
    gate_when_idle = 1'b1;
    cs_active      = 1'b1;
    load_profile(512, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (37) @(negedge clk);
    cs_active = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      check(sck == 1'b0 && !launch_stb && !sample_stb, "R7", int'(sck), 0);
    end
    cs_active = 1'b1;
    count_run(100, 512, 1'b0, 1'b0, 1'b1, 1'b0, "resume");

    // R9: reload mid-run with high idle level
    load_profile(1024, 1'b1, 1'b1, 1'b0, 1'b1);
    count_run(101, 1024, 1'b1, 1'b1, 1'b0, 1'b1, "reload");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule